// File: doc/BRIEF.md
# Windowed watchdog timer

This block watches for regular servicing from software and asks for a system reset when servicing stops. It counts strobes from a slow reference tick, nominally 1 kHz and unrelated to the CPU clock. The strobe arrives already in the block's clock domain as a one-cycle pulse on `tick_i`. A 4-bit period code selects the length of the count. If the selected number of ticks passes with no service, the block raises a reset request for one clock cycle.

In window mode the count has two phases. The closed phase comes first and has its own length code. The open phase follows and uses the period code. A service in the closed phase counts as a fault, just as a missing service by the end of the open phase does. Software changes the configuration with a single write. That write only takes effect soon after the unlock key has been written, and a lock input can freeze the configuration for good. The default period comes from a static input that stands in for a non-volatile setting.

Top module: `win_wdt`

## Requirements
- R1: After reset, `rst_req_o` is low and the watchdog is enabled in normal mode. The period code is taken from `dflt_per_i` and the closed-phase code is 0.
- R2: A period or closed-phase code c from 0 to 10 stands for 2^(c+3) ticks, so 8 to 8192 ticks. Codes 11 to 15 stand for 8192 ticks. Only cycles with `tick_i` high advance the count.
- R3: In normal mode with no service, `rst_req_o` goes high in the cycle after the clock edge that samples the N-th tick, where N is the period length.
- R4: A service (`svc_i` high) that is accepted restarts the count from zero. A service in the same cycle as the final tick still counts as being in time.
- R5: `rst_req_o` is high for exactly one cycle. The request clears the count, so a full new period follows.
- R6: While disabled, the block never requests a reset, and services have no effect.
- R7: In window mode, the closed phase lasts for the closed-phase code's tick count, and the open phase starts once that count has passed. A service during the closed phase raises a request in the next cycle. A service during the open phase restarts the count in the closed phase.
- R8: In window mode, a request is raised when the open phase runs its full length with no service.
- R9: A configuration write (`cfg_we_i`) takes effect only in the 1st to 4th cycle after the key 0xC3 has been written on `key_i` with `key_we_i` high. One accepted write uses up the unlock.
- R10: While `lock_i` is high, every configuration write is ignored.
- R11: An accepted configuration write restarts the count in the closed phase, and no request is raised in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe from the slow reference |
| svc_i | input | 1 | Service strobe from software |
| dflt_per_i | input | 4 | Static default period code |
| lock_i | input | 1 | Blocks all configuration writes while high |
| key_we_i | input | 1 | Key register write strobe |
| key_i | input | 8 | Key value |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | New enable value |
| cfg_win_i | input | 1 | New mode: 1 = window, 0 = normal |
| cfg_per_i | input | 4 | New period (open-phase) code |
| cfg_wper_i | input | 4 | New closed-phase code |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The bench measures the number of ticks to expiry for small, maximum and reserved codes. An off-by-one limit or a wrong clamp of the reserved codes would show up as a different count. It drives a service in the same cycle as the final tick, and a service in the last closed tick and the first open tick of a window. A design that broke these ties the wrong way would request a reset where none is due, or stay quiet when one is. Configuration writes are tried with no key, with a wrong key, in the fourth and the fifth cycle after the key, twice after a single key, and under lock. Any write that slips through shortens the period and shows up as an early request.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int CODE_W     = 4;
  localparam int MAX_CODE   = 10;
  localparam int BASE_SHIFT = 3;
  localparam int LIM_W      = MAX_CODE + BASE_SHIFT + 1;
  localparam int CNT_W      = LIM_W - 1;

  typedef struct packed {
    logic              en;
    logic              win;
    logic [CODE_W-1:0] per;
    logic [CODE_W-1:0] wper;
  } wdt_cfg_t;

  function automatic logic [LIM_W-1:0] code_to_ticks(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] cc;
    cc = (c > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : c;
    return LIM_W'(1) << (cc + BASE_SHIFT);
  endfunction
endpackage

// File: rtl/wwdt_unlock.sv
module wwdt_unlock #(
  parameter int          KEY_W      = 8,
  parameter logic [7:0]  UNLOCK_KEY = 8'hC3,
  parameter int          HOLD       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key,
  input  logic             consume,
  output logic             unlocked
);
  localparam int UW = $clog2(HOLD + 1);
  logic [UW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                                 left_q <= '0;
    else if (key_we && key == KEY_W'(UNLOCK_KEY)) left_q <= UW'(HOLD);
    else if (consume)                        left_q <= '0;
    else if (left_q != '0)                   left_q <= left_q - 1'b1;
  end

  assign unlocked = (left_q != '0);
endmodule

// File: rtl/wwdt_cfg.sv
module wwdt_cfg
  import wwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] dflt_per,
  input  logic              wr,
  input  wdt_cfg_t          wdata,
  output wdt_cfg_t          cfg_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.en   <= 1'b1;
      cfg_q.win  <= 1'b0;
      cfg_q.per  <= dflt_per;
      cfg_q.wper <= '0;
    end else if (wr) begin
      cfg_q <= wdata;
    end
  end
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
  import wwdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  wdt_cfg_t cfg,
  input  logic     restart,
  input  logic     tick,
  input  logic     svc,
  output logic     req
);
  logic [CNT_W-1:0] cnt_q;
  logic             open_q;
  logic [LIM_W-1:0] cur_lim;
  logic             last, early, serve_ok;

  always_comb begin
    cur_lim  = (cfg.win && !open_q) ? code_to_ticks(cfg.wper) : code_to_ticks(cfg.per);
    last     = tick && (({1'b0, cnt_q} + 1'b1) == cur_lim);
    early    = cfg.win && !open_q && svc;
    serve_ok = svc && !early;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
      req    <= 1'b0;
    end else begin
      req <= 1'b0;
      if (restart || !cfg.en) begin
        cnt_q  <= '0;
        open_q <= 1'b0;
      end else if (early) begin
        cnt_q  <= '0;
        open_q <= 1'b0;
        req    <= 1'b1;
      end else if (serve_ok) begin
        cnt_q  <= '0;
        open_q <= 1'b0;
      end else if (tick) begin
        if (last) begin
          cnt_q <= '0;
          if (cfg.win && !open_q) begin
            open_q <= 1'b1;
          end else begin
            open_q <= 1'b0;
            req    <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/win_wdt.sv
module win_wdt
  import wwdt_pkg::*;
#(
  parameter int         KEY_W      = 8,
  parameter logic [7:0] UNLOCK_KEY = 8'hC3,
  parameter int         UNLOCK_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              svc_i,
  input  logic [CODE_W-1:0] dflt_per_i,
  input  logic              lock_i,
  input  logic              key_we_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              cfg_we_i,
  input  logic              cfg_en_i,
  input  logic              cfg_win_i,
  input  logic [CODE_W-1:0] cfg_per_i,
  input  logic [CODE_W-1:0] cfg_wper_i,
  output logic              rst_req_o
);
  logic     unlocked;
  logic     cfg_acc;
  wdt_cfg_t wdata;
  wdt_cfg_t cfg_q;

  assign cfg_acc = cfg_we_i && unlocked && !lock_i;
  assign wdata   = '{en: cfg_en_i, win: cfg_win_i, per: cfg_per_i, wper: cfg_wper_i};

  wwdt_unlock #(.KEY_W(KEY_W), .UNLOCK_KEY(UNLOCK_KEY), .HOLD(UNLOCK_CYC)) u_unlock (
    .clk(clk), .rst(rst), .key_we(key_we_i), .key(key_i),
    .consume(cfg_acc), .unlocked(unlocked)
  );

  wwdt_cfg u_cfg (
    .clk(clk), .rst(rst), .dflt_per(dflt_per_i), .wr(cfg_acc),
    .wdata(wdata), .cfg_q(cfg_q)
  );

  wwdt_core u_core (
    .clk(clk), .rst(rst), .cfg(cfg_q), .restart(cfg_acc),
    .tick(tick_i), .svc(svc_i), .req(rst_req_o)
  );
endmodule

// File: rtl/wwdt_chk.sv
module wwdt_chk
  import wwdt_pkg::*;
#(
  parameter int         KEY_W      = 8,
  parameter logic [7:0] UNLOCK_KEY = 8'hC3
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_i,
  input logic             svc_i,
  input logic             lock_i,
  input logic             key_we_i,
  input logic [KEY_W-1:0] key_i,
  input logic             rst_req_o,
  input logic             unlocked,
  input wdt_cfg_t         cfg
);
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg.en) |-> !rst_req_o); // R6

  AST_WRITE_NEEDS_KEY: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg) |-> $past(unlocked)); // R9

  AST_UNLOCK_FROM_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(key_we_i && key_i == KEY_W'(UNLOCK_KEY))); // R9

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg) |-> !$past(lock_i)); // R10

  AST_UNTICKED_REQ_EARLY: assert property (@(posedge clk) disable iff (rst)
    (rst_req_o && !$past(tick_i)) |-> $past(cfg.win && svc_i)); // R7

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (rst_req_o && !cfg.win) |=> !rst_req_o); // R5
endmodule

bind win_wdt wwdt_chk #(.KEY_W(KEY_W), .UNLOCK_KEY(UNLOCK_KEY)) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .svc_i(svc_i), .lock_i(lock_i),
  .key_we_i(key_we_i), .key_i(key_i), .rst_req_o(rst_req_o),
  .unlocked(unlocked), .cfg(cfg_q)
);

// File: tb/tb_win_wdt.sv
module tb_win_wdt;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] KEY = 8'hC3;
  localparam int NV = 6;
  localparam int VEC [NV][2] = '{'{0, 8}, '{1, 16}, '{4, 128}, '{10, 8192}, '{11, 8192}, '{15, 8192}};

  logic clk = 1'b0;
  logic rst, tick_i, svc_i, lock_i, key_we_i, cfg_we_i, cfg_en_i, cfg_win_i;
  logic [3:0] dflt_per_i, cfg_per_i, cfg_wper_i;
  logic [7:0] key_i;
  logic rst_req_o;

  int total = 0, bad = 0, pulses = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_wdt dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .svc_i(svc_i), .dflt_per_i(dflt_per_i),
    .lock_i(lock_i), .key_we_i(key_we_i), .key_i(key_i), .cfg_we_i(cfg_we_i),
    .cfg_en_i(cfg_en_i), .cfg_win_i(cfg_win_i), .cfg_per_i(cfg_per_i),
    .cfg_wper_i(cfg_wper_i), .rst_req_o(rst_req_o)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    if (rst_req_o) pulses++;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    for (int i = 0; i < n; i++) cyc();
    tick_i = 1'b0;
  endtask

  task automatic service();
    svc_i = 1'b1; cyc(); svc_i = 1'b0;
  endtask

  task automatic key_write(input logic [7:0] k);
    key_we_i = 1'b1; key_i = k; cyc(); key_we_i = 1'b0;
  endtask

  task automatic cfg_write(input bit en, input bit win, input logic [3:0] per, input logic [3:0] wper);
    cfg_en_i = en; cfg_win_i = win; cfg_per_i = per; cfg_wper_i = wper;
    cfg_we_i = 1'b1; cyc(); cfg_we_i = 1'b0;
  endtask

  task automatic wcfg(input bit en, input bit win, input logic [3:0] per, input logic [3:0] wper);
    key_write(KEY);
    cfg_write(en, win, per, wper);
  endtask

  // expect no pulse during n-1 ticks, then one pulse on tick n
  task automatic expect_expiry(input int n, input string rq);
    pulses = 0; ticks(n - 1);
    chk(pulses == 0, rq, pulses, 0);
    ticks(1);
    chk(pulses == 1, rq, pulses, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    rst = 1'b1; tick_i = 0; svc_i = 0; lock_i = 0; key_we_i = 0; key_i = 0;
    cfg_we_i = 0; cfg_en_i = 0; cfg_win_i = 0; cfg_per_i = 0; cfg_wper_i = 0;
    dflt_per_i = 4'd1;
    repeat (5) cyc();
    rst = 1'b0;
    chk(rst_req_o == 1'b0, "R1 reset", rst_req_o, 0);

    // R1 and R3: default code 1 -> 16 ticks
    expect_expiry(16, "R1 R3 default period");

    // R5: pulse is one cycle wide and the count restarts
    cyc();
    chk(rst_req_o == 1'b0, "R5 single pulse", rst_req_o, 0);
    expect_expiry(16, "R5 cleared count");

    // R2 table walk
    for (int v = 0; v < NV; v++) begin
      wcfg(1'b1, 1'b0, 4'(VEC[v][0]), 4'd0);
      pulses = 0; n = 0; tick_i = 1'b1;
      while (pulses == 0 && n < 20000) begin cyc(); n++; end
      tick_i = 1'b0;
      chk(n == VEC[v][1], "R2 period length", n, VEC[v][1]);
    end

    // R4: service restarts; service on the final tick wins
    wcfg(1'b1, 1'b0, 4'd1, 4'd0);
    pulses = 0; ticks(12); service();
    expect_expiry(16, "R4 service restart");
    pulses = 0; ticks(15);
    tick_i = 1'b1; svc_i = 1'b1; cyc(); tick_i = 1'b0; svc_i = 1'b0;
    chk(pulses == 0, "R4 tie with final tick", pulses, 0);
    expect_expiry(16, "R4 after tie");

    // R11: accepted write restarts the count
    pulses = 0; ticks(10); wcfg(1'b1, 1'b0, 4'd1, 4'd0);
    chk(pulses == 0, "R11 no request on write", pulses, 0);
    expect_expiry(16, "R11 restart");

    // R9: write without key is ignored
    pulses = 0; ticks(5); cfg_write(1'b1, 1'b0, 4'd0, 4'd0); ticks(10);
    chk(pulses == 0, "R9 no key", pulses, 0);
    ticks(1);
    chk(pulses == 1, "R9 no key expiry", pulses, 1);
    // R9: write in the 5th cycle after the key is ignored
    pulses = 0; ticks(3); key_write(KEY); repeat (4) cyc(); cfg_write(1'b1, 1'b0, 4'd0, 4'd0);
    ticks(12);
    chk(pulses == 0, "R9 late write", pulses, 0);
    ticks(1);
    chk(pulses == 1, "R9 late write expiry", pulses, 1);
    // R9: wrong key
    key_write(8'h3C); cfg_write(1'b1, 1'b0, 4'd0, 4'd0);
    expect_expiry(16, "R9 wrong key");
    // R9: write in the 4th cycle after the key is taken
    key_write(KEY); repeat (3) cyc(); cfg_write(1'b1, 1'b0, 4'd0, 4'd0);
    expect_expiry(8, "R9 4th cycle write");
    // R9: a single key allows only one write
    key_write(KEY); cfg_write(1'b1, 1'b0, 4'd1, 4'd0); cfg_write(1'b1, 1'b0, 4'd0, 4'd0);
    expect_expiry(16, "R9 unlock used up");

    // R10: lock blocks writes
    lock_i = 1'b1; wcfg(1'b1, 1'b0, 4'd0, 4'd0);
    expect_expiry(16, "R10 locked");
    lock_i = 1'b0;

    // R6: disabled
    wcfg(1'b0, 1'b0, 4'd0, 4'd0);
    pulses = 0; ticks(50); service();
    chk(pulses == 0, "R6 disabled", pulses, 0);
    wcfg(1'b0, 1'b1, 4'd0, 4'd0);
    service(); ticks(40);
    chk(pulses == 0, "R6 disabled window", pulses, 0);

    // R7 and R8: closed 8, open 8
    wcfg(1'b1, 1'b1, 4'd0, 4'd0);
    pulses = 0; ticks(3); service();
    chk(pulses == 1, "R7 early service", pulses, 1);
    pulses = 0; ticks(8); ticks(2); service();
    chk(pulses == 0, "R7 open service", pulses, 0);
    ticks(7); service();
    chk(pulses == 1, "R7 last closed tick", pulses, 1);
    expect_expiry(16, "R8 no service");
    pulses = 0; ticks(8); service();
    chk(pulses == 0, "R7 first open cycle", pulses, 0);
    // closed 16, open 8
    wcfg(1'b1, 1'b1, 4'd0, 4'd1);
    pulses = 0; ticks(15); service();
    chk(pulses == 1, "R7 longer closed", pulses, 1);
    pulses = 0; ticks(16); service();
    chk(pulses == 0, "R7 open after 16", pulses, 0);
    expect_expiry(24, "R8 closed 16 open 8");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule